// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit saturating counters. A small shift register records the outcomes of the most recently resolved branches. The fetch stage presents the set bits of a fetch address, which are the low PC bits above the instruction alignment. The block returns a taken/not-taken guess in the same cycle. The history value picks one of several counters inside the set that the address selects, so the same branch can be predicted differently depending on what the branches before it did.

When a branch resolves, the execute stage presents its set bits and its real outcome. The block then trains one counter, the one addressed by those bits and the current history, and shifts the outcome into the history. The table stores no tags. Unrelated branches whose set bits match share counters. Setting the history length to zero turns the block into a plain table of counters indexed by address alone.

Top module: `corr_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history register holds zero, so every lookup returns not taken.
- R2: `lk_taken` is the most significant bit of the addressed counter, formed combinationally in the cycle the address is presented.
- R3: The table index is `{pc, history}`, with the history in the low HIST_BITS bits, so each set owns 2^HIST_BITS counters and the history alone selects among them.
- R4: On an update the counter increments when the branch was taken and decrements when it was not, saturating at 11 and 00 without wrapping.
- R5: An update writes only the counter addressed by `up_pc` and the pre-update history; every other counter keeps its value.
- R6: On each update the history shifts left by one with the outcome (1 = taken) entering bit 0; the counter trained in that cycle is indexed with the history before the shift.
- R7: A counter in a strong state (00 or 11) flips its prediction only after two consecutive mispredictions.
- R8: No address tag is kept: two branches whose set bits and history match read and train the same counter.
- R9: When a lookup and an update address the same counter in the same cycle, the lookup returns the value held before the update.
- R10: With HIST_BITS = 0 the block is a plain counter table indexed by `pc` alone, and no update changes which counter a given `pc` reads.
- R11: While `up_valid` is low, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | SET_BITS | Set bits of the fetch address being predicted |
| lk_taken | output | 1 | Prediction, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | SET_BITS | Set bits of the resolved branch address |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds two copies side by side, driven with the same stimulus. The first has three set bits and two history bits, giving 32 counters. The second has three set bits and no history. The small table lets random traffic drive counters into both saturation limits and produce frequent aliasing and same-cycle lookup/update collisions. The history-free copy has a stable index, so directed sequences can step a single counter through its hysteresis and saturation without the history moving the index between steps.

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int SET_BITS  = 6,
  parameter int HIST_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] lk_pc,
  output logic                lk_taken,
  input  logic                up_valid,
  input  logic [SET_BITS-1:0] up_pc,
  input  logic                up_taken
);
  localparam int IDX_W = SET_BITS + HIST_BITS;
  localparam int DEPTH = 1 << IDX_W;
  localparam int GW    = (HIST_BITS > 0) ? HIST_BITS : 1;

  logic [GW-1:0]    ghr;
  logic [1:0]       cnt [DEPTH];
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [1:0]       up_cnt, up_nxt;

  generate
    if (HIST_BITS > 0) begin : g_hist
      assign lk_idx = {lk_pc, ghr};
      assign up_idx = {up_pc, ghr};
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        ghr <= '0;
        else if (up_valid) ghr <= (ghr << 1) | GW'(up_taken);
    end else begin : g_flat
      assign lk_idx = lk_pc;
      assign up_idx = up_pc;
      assign ghr    = '0;
    end
  endgenerate

  assign lk_taken = cnt[lk_idx][1];
  assign up_cnt   = cnt[up_idx];

  always_comb begin
    up_nxt = up_cnt;
    if (up_taken && up_cnt != 2'b11)       up_nxt = up_cnt + 2'b01;
    else if (!up_taken && up_cnt != 2'b00) up_nxt = up_cnt - 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= 2'b01;
    end else if (up_valid) begin
      cnt[up_idx] <= up_nxt;
    end
endmodule

module corr_predictor_chk #(
  parameter int SET_BITS  = 6,
  parameter int HIST_BITS = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          up_valid,
  input logic                          up_taken,
  input logic [SET_BITS+HIST_BITS-1:0] up_idx,
  input logic [1:0]                    up_cnt,
  input logic [((HIST_BITS>0)?HIST_BITS:1)-1:0] ghr,
  input logic [1:0]                    cnt [1 << (SET_BITS+HIST_BITS)]
);
  logic                          v_q, t_q;
  logic [SET_BITS+HIST_BITS-1:0] i_q;
  logic [1:0]                    c_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v_q <= 1'b0; t_q <= 1'b0; i_q <= '0; c_q <= 2'b01;
    end else begin
      v_q <= up_valid; t_q <= up_taken; i_q <= up_idx; c_q <= up_cnt;
    end

  // R4
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && t_q && c_q == 2'b11) |-> cnt[i_q] == 2'b11);
  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !t_q && c_q == 2'b00) |-> cnt[i_q] == 2'b00);
  // R7
  step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> (t_q ? (cnt[i_q] >= c_q) : (cnt[i_q] <= c_q)));
  // R11
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr));

  generate
    if (HIST_BITS > 0) begin : g_h
      // R6
      hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> ghr[0] == $past(up_taken));
    end
  endgenerate
endmodule

bind corr_predictor corr_predictor_chk #(.SET_BITS(SET_BITS), .HIST_BITS(HIST_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
  .up_idx(up_idx), .up_cnt(up_cnt), .ghr(ghr), .cnt(cnt));

// File: tb/corr_predictor_tb.sv
`timescale 1ns/1ps
module corr_predictor_tb;
  localparam int SB = 3;
  localparam int HB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SB-1:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 1'b0, up_taken = 1'b0;
  logic lk_m, lk_f;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [1:0]    m_cnt [1 << (SB+HB)];
  logic [HB-1:0] m_ghr;
  logic [1:0]    f_cnt [1 << SB];

  always #2 clk = ~clk;

  corr_predictor #(.SET_BITS(SB), .HIST_BITS(HB)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_m),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  corr_predictor #(.SET_BITS(SB), .HIST_BITS(0)) u_dut_flat (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_f),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [SB-1:0] lp, input logic uv,
                      input logic [SB-1:0] upc, input logic ut, input string tag);
    @(negedge clk);
    lk_pc = lp; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    chk({tag, " main"}, lk_m, m_cnt[{lp, m_ghr}][1]);
    chk({tag, " flat"}, lk_f, f_cnt[lp][1]);
    @(posedge clk);
    if (uv) begin
      m_cnt[{upc, m_ghr}] = sat(m_cnt[{upc, m_ghr}], ut);
      m_ghr = {m_ghr[HB-2:0], ut};
      f_cnt[upc] = sat(f_cnt[upc], ut);
    end
  endtask

  task automatic expect_m(input logic [SB-1:0] lp, input logic e, input string tag);
    @(negedge clk); lk_pc = lp; up_valid = 1'b0; #1;
    chk(tag, lk_m, e);
  endtask

  task automatic expect_f(input logic [SB-1:0] lp, input logic e, input string tag);
    @(negedge clk); lk_pc = lp; up_valid = 1'b0; #1;
    chk(tag, lk_f, e);
  endtask

  initial begin
    logic [31:0] pc_a, pc_b;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << (SB+HB)); i++) m_cnt[i] = 2'b01;
    for (int i = 0; i < (1 << SB); i++) f_cnt[i] = 2'b01;
    m_ghr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, every set predicts not taken
    for (int p = 0; p < (1 << SB); p++) begin
      expect_m(SB'(p), 1'b0, "R1 main");
      expect_f(SB'(p), 1'b0, "R1 flat");
    end
    // R11: noise on update fields without up_valid
    for (int k = 0; k < 8; k++) step(SB'(k), 1'b0, SB'(7-k), k[0], "R11");
    for (int p = 0; p < (1 << SB); p++) expect_m(SB'(p), 1'b0, "R11 hold");

    // R3 / R6: history picks a fresh counter of set 1
    step(3'd0, 1'b1, 3'd1, 1'b1, "R6");
    step(3'd0, 1'b1, 3'd1, 1'b1, "R6");
    expect_m(3'd1, 1'b0, "R3 history 11");
    step(3'd0, 1'b1, 3'd3, 1'b0, "R6");
    step(3'd0, 1'b1, 3'd3, 1'b0, "R6");
    expect_m(3'd1, 1'b1, "R3 history 00");
    // R10: flat table indexed by pc only
    expect_f(3'd1, 1'b1, "R10");
    expect_f(3'd3, 1'b0, "R10");
    // R5: untouched neighbour
    expect_f(3'd0, 1'b0, "R5");

    // R7: strong taken needs two misses
    step(3'd0, 1'b1, 3'd1, 1'b0, "R7");
    expect_f(3'd1, 1'b1, "R7 one miss");
    step(3'd0, 1'b1, 3'd1, 1'b0, "R7");
    expect_f(3'd1, 1'b0, "R7 two misses");

    // R4: saturation at both ends
    step(3'd0, 1'b1, 3'd3, 1'b0, "R4");
    step(3'd0, 1'b1, 3'd3, 1'b1, "R4");
    expect_f(3'd3, 1'b0, "R4 low sat");
    for (int k = 0; k < 4; k++) step(3'd0, 1'b1, 3'd1, 1'b1, "R4");
    step(3'd0, 1'b1, 3'd1, 1'b0, "R4");
    expect_f(3'd1, 1'b1, "R4 high sat");

    // R9: same-cycle lookup sees old value
    step(3'd4, 1'b1, 3'd4, 1'b1, "R9 same cycle");
    expect_f(3'd4, 1'b1, "R9 next cycle");

    // R8: aliasing branches share a counter
    pc_a = 32'h0000_0108; pc_b = 32'h0000_0408;
    step(3'd0, 1'b1, pc_a[4:2], 1'b1, "R8");
    step(3'd0, 1'b1, pc_a[4:2], 1'b1, "R8");
    expect_f(pc_b[4:2], 1'b1, "R8 alias");

    // R2 R5: random traffic against the model
    for (int n = 0; n < 3000; n++)
      step(SB'($urandom), ($urandom % 4) != 0, SB'($urandom), $urandom % 3 != 0, "R2 R5 random");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule